// File: doc/BRIEF.md
# Firmware Hub memory-cycle header decoder

This block is the peripheral-side front end for a Firmware Hub memory cycle on a 4-bit multiplexed address/data bus framed by an active-low frame strobe. Each clock it samples the bus nibble and the frame strobe. While the strobe is low it looks for a read or write start code. It then compares a one-clock device-select nibble against four strapped identity inputs, gathers a seven-nibble address and checks a one-clock transfer-size nibble.

When the header is complete and valid, the decoder raises a one-cycle request. The request carries the transfer direction, the low 18 address bits and a flag that tells array accesses apart from register-space accesses. A header whose device select does not match the straps gives a one-cycle ignore pulse. A header that asks for anything other than a single byte gives a one-cycle error pulse. The stages after the header (bus turnaround, sync, wait states and data) sit in downstream logic that consumes the request.

Top module: `fwh_hdr_dec`

## Requirements
- R1: While `rst` is high at a clock edge, the next clock leaves `req_valid`, `req_write`, `req_array`, `req_addr`, `hdr_err` and `hdr_ignore` all at zero.
- R2: A start nibble of 4'b1101 opens a read (`req_write` = 0) and 4'b1110 opens a write (`req_write` = 1). Any other start nibble produces no request, no error and no ignore pulse.
- R3: When `frame_n` is low for several clocks in a row, only the nibble on the last low clock counts as the start code.
- R4: The nibble on the first clock after the start is compared with `id_strap`. On a mismatch `hdr_ignore` pulses for one cycle on the following clock and the rest of the header produces no request.
- R5: The address arrives as seven nibbles, most significant first (A27 down to A0). `req_addr` equals A17..A0. Bits A27..A24 and A21..A18 have no effect on any output.
- R6: `req_array` equals address bit A22: 1 selects the memory array, 0 selects register space.
- R7: A size nibble other than 4'b0000 produces no request. Instead `hdr_err` pulses for one cycle on the clock after the size nibble, and the decoder returns to idle.
- R8: A low `frame_n` at any clock of a header in progress abandons that header and evaluates the nibble as a new start code.
- R9: With size 4'b0000, `req_valid` is high for exactly one cycle, on the clock after the size nibble, which is ten clocks after the last start clock.
- R10: At most one of `req_valid`, `hdr_err` and `hdr_ignore` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low cycle framing strobe |
| lad | input | 4 | Multiplexed bus nibble |
| id_strap | input | 4 | Strapped device identity |
| req_valid | output | 1 | One-cycle request strobe |
| req_write | output | 1 | Request direction, 1 = write |
| req_array | output | 1 | 1 = memory array, 0 = register space |
| req_addr | output | 18 | Byte address A17..A0 |
| hdr_err | output | 1 | Unsupported size pulse |
| hdr_ignore | output | 1 | Device-select mismatch pulse |

## Verification
The bench aims at a start strobe held low across several clocks. A decoder that latched the first low nibble instead of the last would report the wrong direction, or would open a header on junk. It re-asserts the frame strobe partway through an address. A design without the abort path would then emit a request built from mixed nibbles, or none at all. It also sends addresses that differ only in the don't-care bits, plus non-zero sizes and wrong device selects. A decoder that sliced the wrong bits, reversed nibble order or leaked a request past a bad size would show a wrong address or space flag, or a stray request.

// File: rtl/fwh_hdr_pkg.sv
package fwh_hdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_IDSEL = 2'd1,
        ST_ADDR  = 2'd2,
        ST_SIZE  = 2'd3
    } fwh_state_e;

    localparam logic [3:0] START_RD = 4'b1101;
    localparam logic [3:0] START_WR = 4'b1110;
    localparam logic [3:0] SIZE_ONE = 4'b0000;

endpackage

// File: rtl/fwh_start_class.sv
module fwh_start_class
    import fwh_hdr_pkg::*;
(
    input  logic [3:0] nib,
    output logic       hit,
    output logic       is_write
);
    always_comb begin
        hit      = (nib == START_RD) || (nib == START_WR);
        is_write = (nib == START_WR);
    end
endmodule

// File: rtl/fwh_addr_collect.sv
module fwh_addr_collect #(
    parameter int NIBBLES = 7,
    localparam int AW = 4 * NIBBLES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic [3:0]    nib,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (shift_en) addr_d = {addr_q[AW-5:0], nib};
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/fwh_hdr_dec.sv
module fwh_hdr_dec
    import fwh_hdr_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    parameter int OUT_AW       = 18,
    parameter int SPACE_BIT    = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [3:0]        lad,
    input  logic [3:0]        id_strap,
    output logic              req_valid,
    output logic              req_write,
    output logic              req_array,
    output logic [OUT_AW-1:0] req_addr,
    output logic              hdr_err,
    output logic              hdr_ignore
);
    localparam int AW    = 4 * ADDR_NIBBLES;
    localparam int CNT_W = (ADDR_NIBBLES > 1) ? $clog2(ADDR_NIBBLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBBLES - 1);

    typedef struct packed {
        fwh_state_e       st;
        logic             wr;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic             err;
        logic             ign;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          start_hit;
    logic          start_wr;
    logic          shift_en;
    logic [AW-1:0] addr_full;

    fwh_start_class u_start (
        .nib      (lad),
        .hit      (start_hit),
        .is_write (start_wr)
    );

    assign shift_en = frame_n && (ctl_q.st == ST_ADDR);

    fwh_addr_collect #(.NIBBLES(ADDR_NIBBLES)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .nib      (lad),
        .addr     (addr_full)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = 1'b0;
        ctl_d.err = 1'b0;
        ctl_d.ign = 1'b0;
        if (!frame_n) begin
            // Every low-frame clock re-arms; the last one decides.
            if (start_hit) begin
                ctl_d.st = ST_IDSEL;
                ctl_d.wr = start_wr;
            end else begin
                ctl_d.st = ST_IDLE;
            end
        end else begin
            case (ctl_q.st)
                ST_IDLE: ctl_d.st = ST_IDLE;
                ST_IDSEL: begin
                    if (lad == id_strap) begin
                        ctl_d.st  = ST_ADDR;
                        ctl_d.cnt = '0;
                    end else begin
                        ctl_d.st  = ST_IDLE;
                        ctl_d.ign = 1'b1;
                    end
                end
                ST_ADDR: begin
                    if (ctl_q.cnt == CNT_LAST) ctl_d.st = ST_SIZE;
                    else                       ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
                ST_SIZE: begin
                    ctl_d.st = ST_IDLE;
                    if (lad == SIZE_ONE) ctl_d.vld = 1'b1;
                    else                 ctl_d.err = 1'b1;
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.wr  <= 1'b0;
            ctl_q.cnt <= '0;
            ctl_q.vld <= 1'b0;
            ctl_q.err <= 1'b0;
            ctl_q.ign <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_valid  = ctl_q.vld;
    assign req_write  = ctl_q.wr;
    assign req_array  = addr_full[SPACE_BIT];
    assign req_addr   = addr_full[OUT_AW-1:0];
    assign hdr_err    = ctl_q.err;
    assign hdr_ignore = ctl_q.ign;
endmodule

// File: rtl/fwh_hdr_dec_chk.sv
module fwh_hdr_dec_chk (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic req_valid,
    input logic hdr_err,
    input logic hdr_ignore
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!req_valid && !hdr_err && !hdr_ignore)); // R1

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid); // R9

    AST_FRAME_ABORTS: assert property (@(posedge clk) disable iff (rst)
        !frame_n |=> (!req_valid && !hdr_err)); // R8

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_valid, hdr_err, hdr_ignore})); // R10

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        hdr_err |=> !hdr_err); // R7
endmodule

bind fwh_hdr_dec fwh_hdr_dec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n),
    .req_valid  (req_valid),
    .hdr_err    (hdr_err),
    .hdr_ignore (hdr_ignore)
);

// File: tb/sim_fwh_hdr_dec.sv
`timescale 1ns/1ps
module sim_fwh_hdr_dec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1;
    logic [3:0]  lad = 4'h0;
    logic [3:0]  id_strap = 4'h5;
    logic        req_valid, req_write, req_array, hdr_err, hdr_ignore;
    logic [17:0] req_addr;

    always #2 clk = ~clk;

    fwh_hdr_dec u0 (
        .clk(clk), .rst(rst), .frame_n(frame_n), .lad(lad), .id_strap(id_strap),
        .req_valid(req_valid), .req_write(req_write), .req_array(req_array),
        .req_addr(req_addr), .hdr_err(hdr_err), .hdr_ignore(hdr_ignore)
    );

    int checks = 0;
    int fails  = 0;
    int idx, n_vld, n_err, n_ign, vld_idx;
    logic        cap_wr, cap_arr;
    logic [17:0] cap_addr;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    function automatic bit is_fwh(input logic [3:0] s);
        return (s == 4'b1101) || (s == 4'b1110);
    endfunction

    task automatic clr_acc();
        idx = 0; n_vld = 0; n_err = 0; n_ign = 0; vld_idx = -1;
        cap_wr = 0; cap_arr = 0; cap_addr = '0;
    endtask

    task automatic drv(input logic fr, input logic [3:0] nib);
        frame_n = fr;
        lad     = nib;
        @(posedge clk);
        @(negedge clk);
        if (req_valid) begin
            n_vld++; vld_idx = idx;
            cap_wr = req_write; cap_arr = req_array; cap_addr = req_addr;
        end
        if (hdr_err)    n_err++;
        if (hdr_ignore) n_ign++;
        idx++;
    endtask

    task automatic hdr_body(input logic [3:0] st, input logic [3:0] idn,
                            input logic [27:0] a, input logic [3:0] ms);
        drv(1'b0, st);
        drv(1'b1, idn);
        for (int k = 0; k < 7; k++) drv(1'b1, a[27-4*k -: 4]);
        drv(1'b1, ms);
        drv(1'b1, 4'h0);
        drv(1'b1, 4'h0);
    endtask

    task automatic check_hdr(input string tag, input logic [3:0] st, input logic [3:0] idn,
                             input logic [27:0] a, input logic [3:0] ms, input int base);
        bit fwh, match, good;
        fwh   = is_fwh(st);
        match = (idn == id_strap);
        good  = fwh && match && (ms == 4'h0);
        chk({tag, " R2/R9 request count"}, n_vld, good ? 1 : 0);
        chk({tag, " R4 ignore count"}, n_ign, (fwh && !match) ? 1 : 0);
        chk({tag, " R7 error count"}, n_err, (fwh && match && ms != 0) ? 1 : 0);
        if (good) begin
            chk({tag, " R9 request cycle"}, vld_idx, base + 9);
            chk({tag, " R2 direction"}, cap_wr, st == 4'b1110);
            chk({tag, " R5 address"}, cap_addr, a[17:0]);
            chk({tag, " R6 space flag"}, cap_arr, a[22]);
        end
    endtask

    initial begin
        logic [3:0]  st, idn, ms;
        logic [27:0] a;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 req_valid", req_valid, 0);
        chk("R1 req_write", req_write, 0);
        chk("R1 req_array", req_array, 0);
        chk("R1 req_addr", req_addr, 0);
        chk("R1 hdr_err", hdr_err, 0);
        chk("R1 hdr_ignore", hdr_ignore, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 read and write, R6 both spaces
        clr_acc(); hdr_body(4'b1101, 4'h5, 28'h0412345, 4'h0); check_hdr("R2 read", 4'b1101, 4'h5, 28'h0412345, 4'h0, 0);
        clr_acc(); hdr_body(4'b1110, 4'h5, 28'h003ABCD, 4'h0); check_hdr("R6 write reg", 4'b1110, 4'h5, 28'h003ABCD, 4'h0, 0);
        // R2 non-FWH start
        clr_acc(); hdr_body(4'b0000, 4'h5, 28'h0412345, 4'h0); check_hdr("R2 plain start", 4'b0000, 4'h5, 28'h0412345, 4'h0, 0);

        // R5: don't-care bits A27..A24, A21..A18 changed
        clr_acc(); hdr_body(4'b1101, 4'h5, 28'hF7C0001 | 28'h0000000, 4'h0);
        check_hdr("R5 dontcare set", 4'b1101, 4'h5, 28'hF7C0001, 4'h0, 0);
        chk("R5 dontcare addr", cap_addr, 18'h00001);
        chk("R5 dontcare space", cap_arr, 1'b1);

        // R4 mismatch, R7 bad size
        clr_acc(); hdr_body(4'b1110, 4'hA, 28'h0400010, 4'h0); check_hdr("R4 mismatch", 4'b1110, 4'hA, 28'h0400010, 4'h0, 0);
        clr_acc(); hdr_body(4'b1101, 4'h5, 28'h0400010, 4'h1); check_hdr("R7 size1", 4'b1101, 4'h5, 28'h0400010, 4'h1, 0);
        clr_acc(); hdr_body(4'b1101, 4'h5, 28'h0400010, 4'hF); check_hdr("R7 sizeF", 4'b1101, 4'h5, 28'h0400010, 4'hF, 0);

        // R3: several low clocks; last start nibble decides
        clr_acc(); drv(1'b0, 4'b1101); hdr_body(4'b1110, 4'h5, 28'h0455555, 4'h0);
        check_hdr("R3 last start wins", 4'b1110, 4'h5, 28'h0455555, 4'h0, 1);
        clr_acc(); drv(1'b0, 4'b1110); hdr_body(4'b0011, 4'h5, 28'h0455555, 4'h0);
        check_hdr("R3 last junk wins", 4'b0011, 4'h5, 28'h0455555, 4'h0, 1);

        // R8: abort mid-address, restart
        clr_acc();
        drv(1'b0, 4'b1101); drv(1'b1, 4'h5); drv(1'b1, 4'h9); drv(1'b1, 4'h9); drv(1'b1, 4'h9);
        hdr_body(4'b1110, 4'h5, 28'h0012345, 4'h0);
        check_hdr("R8 abort restart", 4'b1110, 4'h5, 28'h0012345, 4'h0, 5);
        // R8: abort on the size clock
        clr_acc();
        drv(1'b0, 4'b1101); drv(1'b1, 4'h5);
        for (int k = 0; k < 7; k++) drv(1'b1, 4'h3);
        drv(1'b0, 4'h0); drv(1'b1, 4'h0); drv(1'b1, 4'h0);
        chk("R8 abort at size no request", n_vld, 0);
        chk("R8 abort at size no error", n_err, 0);

        // Random mix, fixed seed
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 60; i++) begin
            case ($urandom_range(3, 0))
                0: st = 4'b1101;
                1: st = 4'b1110;
                2: st = 4'b1110;
                default: st = 4'($urandom);
            endcase
            id_strap = 4'($urandom);
            idn = ($urandom_range(9, 0) < 8) ? id_strap : 4'($urandom);
            ms  = ($urandom_range(9, 0) < 8) ? 4'h0 : 4'($urandom);
            a   = 28'($urandom);
            clr_acc(); hdr_body(st, idn, a, ms);
            check_hdr("R10 random", st, idn, a, ms, 0);
        end
        summary();
    end
endmodule